// File: doc/BRIEF.md
# Register File with Pointer Addressing

This block is the working-register storage of a small 8-bit RISC core. It holds thirty-two byte-wide registers. Two read ports are combinational, so an instruction can fetch both operands and write its result back in the same clock. The top six registers pair up into three 16-bit data pointers. The block turns the selected pointer into an effective data address for indirect loads and stores. It supports plain, post-increment, pre-decrement and displacement forms, and it writes the modified pointer back at the clock edge.

The block also decodes every effective address into a data-space region: the register file itself, a 64-entry I/O window, 128 bytes of SRAM, or nothing. It reports the region code and the offset inside that region. An indirect access that lands in the register region is served here: the load byte comes out on a port, and a store updates the register. A separate word path adds a 6-bit immediate to any register pair, or subtracts it, as one 16-bit value. The core's decoder drives all control inputs. The SRAM and the I/O peripherals sit outside and consume the region select and offset.

Top module: `regfile_ptr`

## Requirements
- R1: A clock edge with `rst_n` low clears all 32 registers to 0x00.
- R2: `rd_data_a`/`rd_data_b` show the register selected by `rd_sel_a`/`rd_sel_b` combinationally. A byte written through `wr_en` becomes visible only after the next rising edge.
- R3: Post-increment (`ptr_mode` = 1) gives the current pointer as `eff_addr`. After the edge the pointer holds that value plus 1, with the carry passing from the low byte into the high byte.
- R4: Pre-decrement (`ptr_mode` = 2) gives the pointer minus 1 as `eff_addr`, and the pointer takes that value at the edge, borrowing across the bytes.
- R5: Plain mode (`ptr_mode` = 0) gives the pointer as `eff_addr` and leaves the pointer unchanged.
- R6: Displacement mode (`ptr_mode` = 3) with Y or Z gives the pointer plus the unsigned 6-bit `ptr_disp` (0..63) and leaves the pointer unchanged. With X selected it acts as plain mode.
- R7: `ptr_sel` 0 selects X = registers 27:26, 1 selects Y = 29:28, and 2 or 3 select Z = 31:30. In each pair the low byte is at the even index.
- R8: `region` is 0 for addresses 0x00–0x1F (offset = address), 1 for 0x20–0x5F (offset = address − 0x20), and 2 for 0x60–0xDF (offset = address − 0x60). In each of these cases `out_of_range` is 0.
- R9: For addresses above 0xDF, `region` is 3, `out_of_range` is 1, `region_off` is 0 and `acc_rdata` is 0x00.
- R10: In region 0, `acc_rdata` shows the addressed register, and `ptr_en` with `acc_st` writes `acc_wdata` into it. A store outside region 0 changes no register.
- R11: `word_en` adds `word_imm` to the pair `word_pair` (registers 2p+1:2p), or subtracts it when `word_sub` = 1, as one 16-bit value that wraps modulo 2^16.
- R12: When a byte write and a pointer write-back target the same register in one cycle, the byte write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_sel_a | input | 5 | Operand A register index |
| rd_sel_b | input | 5 | Operand B register index |
| rd_data_a | output | 8 | Operand A value |
| rd_data_b | output | 8 | Operand B value |
| wr_en | input | 1 | Byte write enable (result or load data) |
| wr_sel | input | 5 | Byte write register index |
| wr_data | input | 8 | Byte write value |
| word_en | input | 1 | Pair add/subtract enable |
| word_sub | input | 1 | 1 = subtract, 0 = add |
| word_pair | input | 4 | Pair index p (registers 2p+1:2p) |
| word_imm | input | 6 | Unsigned word immediate |
| ptr_en | input | 1 | Indirect access this cycle |
| ptr_sel | input | 2 | Pointer select (0 X, 1 Y, 2/3 Z) |
| ptr_mode | input | 2 | 0 plain, 1 post-inc, 2 pre-dec, 3 displacement |
| ptr_disp | input | 6 | Displacement q |
| acc_st | input | 1 | Indirect access is a store |
| acc_wdata | input | 8 | Store data |
| eff_addr | output | 16 | Effective data address |
| region | output | 2 | 0 registers, 1 I/O, 2 SRAM, 3 none |
| region_off | output | 8 | Offset inside the region |
| out_of_range | output | 1 | Address above the SRAM |
| acc_rdata | output | 8 | Register-region load data, 0 elsewhere |

## Verification
Each pointer is preloaded with values that sit on a byte boundary, such as 0x00FF and 0x0100, so that a pointer update which fails to carry or borrow into the high byte shows up. The displacement tests use q = 0 and q = 63 and also the X pointer, which separates a correct adder from one that ignores q or applies it to every pointer. The effective address is moved across each region edge (0x1F/0x20, 0x5F/0x60, 0xDF/0xE0) to catch off-by-one bounds and wrong offset bases. Collision cases drive a byte write and a pointer write-back at the same register, which shows the winning source.

// File: rtl/rfp_pkg.sv
// Package rfp_pkg: shared encodings for the register file and its address unit.
// Assumes the encodings below match the instruction decoder driving the block.
package rfp_pkg;
    typedef enum logic [1:0] {
        AM_PLAIN   = 2'd0,
        AM_POSTINC = 2'd1,
        AM_PREDEC  = 2'd2,
        AM_DISP    = 2'd3
    } amode_t;

    typedef enum logic [1:0] {
        RG_REG  = 2'd0,
        RG_IO   = 2'd1,
        RG_SRAM = 2'd2,
        RG_NONE = 2'd3
    } region_t;
endpackage

// File: rtl/rfp_store.sv
// Module rfp_store: the register array. It has four write sources, resolved per
// register with a fixed priority: byte write > indirect store > pointer
// write-back > word operation.
// Assumes the caller presents at most one value per source per cycle.
module rfp_store #(
    parameter int NREG = 32,
    parameter int DW   = 8,
    localparam int SW  = $clog2(NREG),
    localparam int PW  = SW - 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [SW-1:0]             wr_sel,
    input  logic [DW-1:0]             wr_data,
    input  logic                      st_en,
    input  logic [SW-1:0]             st_sel,
    input  logic [DW-1:0]             st_data,
    input  logic                      wb_en,
    input  logic [PW-1:0]             wb_pair,
    input  logic [2*DW-1:0]           wb_val,
    input  logic                      wd_en,
    input  logic [PW-1:0]             wd_pair,
    input  logic [2*DW-1:0]           wd_val,
    output logic [NREG-1:0][DW-1:0]   regs_q
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam int PAIR = i / 2;
        localparam int HI   = i % 2;
        logic [DW-1:0] q;

        // Update one register from the highest-priority source that targets it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && wr_sel == SW'(i)) begin
                q <= wr_data;
            end else if (st_en && st_sel == SW'(i)) begin
                q <= st_data;
            end else if (wb_en && wb_pair == PW'(PAIR)) begin
                q <= wb_val[HI*DW +: DW];
            end else if (wd_en && wd_pair == PW'(PAIR)) begin
                q <= wd_val[HI*DW +: DW];
            end
        end

        assign regs_q[i] = q;
    end

    // R12: a byte write to a register of the written-back pointer pair wins.
    a_r12_byte_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wb_en && wr_sel[SW-1:1] == wb_pair)
        |=> regs_q[$past(wr_sel)] == $past(wr_data));
endmodule

// File: rtl/rfp_agu.sv
// Module rfp_agu: effective-address and pointer-update logic for one indirect access.
// Assumes that only Y and Z take a displacement; X in displacement mode acts as plain.
module rfp_agu #(
    parameter int PTRW = 16,
    parameter int QW   = 6
) (
    input  logic [PTRW-1:0] ptr_val,
    input  logic [1:0]      mode,
    input  logic            is_x,
    input  logic [QW-1:0]   disp,
    output logic [PTRW-1:0] eff_addr,
    output logic            wb_en,
    output logic [PTRW-1:0] wb_val
);
    import rfp_pkg::*;

    amode_t m;
    assign m = amode_t'(mode);

    // Select the address and the optional new pointer value for the mode.
    always_comb begin
        eff_addr = ptr_val;
        wb_en    = 1'b0;
        wb_val   = ptr_val;
        case (m)
            AM_POSTINC: begin
                wb_en  = 1'b1;
                wb_val = ptr_val + PTRW'(1);
            end
            AM_PREDEC: begin
                eff_addr = ptr_val - PTRW'(1);
                wb_en    = 1'b1;
                wb_val   = ptr_val - PTRW'(1);
            end
            AM_DISP: begin
                if (!is_x) eff_addr = ptr_val + PTRW'(disp);
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rfp_region.sv
// Module rfp_region: maps a data address onto registers, the I/O window, SRAM or nothing.
// Assumes the three regions are contiguous from address 0 in that order.
module rfp_region #(
    parameter int AW     = 16,
    parameter int OW     = 8,
    parameter int REG_SZ = 32,
    parameter int IO_SZ  = 64,
    parameter int RAM_SZ = 128
) (
    input  logic [AW-1:0] addr,
    output logic [1:0]    region,
    output logic [OW-1:0] offset,
    output logic          oor
);
    import rfp_pkg::*;

    localparam int IO_BASE  = REG_SZ;
    localparam int RAM_BASE = REG_SZ + IO_SZ;
    localparam int END_ADDR = RAM_BASE + RAM_SZ;

    region_t rg;

    // Compare the address against each region bound and rebase the offset.
    always_comb begin
        oor    = 1'b0;
        offset = '0;
        if (addr < AW'(IO_BASE)) begin
            rg     = RG_REG;
            offset = OW'(addr);
        end else if (addr < AW'(RAM_BASE)) begin
            rg     = RG_IO;
            offset = OW'(addr - AW'(IO_BASE));
        end else if (addr < AW'(END_ADDR)) begin
            rg     = RG_SRAM;
            offset = OW'(addr - AW'(RAM_BASE));
        end else begin
            rg  = RG_NONE;
            oor = 1'b1;
        end
    end

    assign region = rg;
endmodule

// File: rtl/regfile_ptr.sv
// Module regfile_ptr: 32x8 register file with two combinational read ports, a byte
// write port, a pair add/subtract path, and three pointer pairs at the top that
// drive indirect data addressing and region decode.
// Assumes one indirect access per cycle and that the decoder orders its requests.
module regfile_ptr #(
    parameter int NREG   = 32,
    parameter int DW     = 8,
    parameter int QW     = 6,
    parameter int IMMW   = 6,
    parameter int IO_SZ  = 64,
    parameter int RAM_SZ = 128,
    localparam int SW    = $clog2(NREG),
    localparam int PW    = SW - 1,
    localparam int PTRW  = 2 * DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SW-1:0]   rd_sel_a,
    input  logic [SW-1:0]   rd_sel_b,
    output logic [DW-1:0]   rd_data_a,
    output logic [DW-1:0]   rd_data_b,
    input  logic            wr_en,
    input  logic [SW-1:0]   wr_sel,
    input  logic [DW-1:0]   wr_data,
    input  logic            word_en,
    input  logic            word_sub,
    input  logic [PW-1:0]   word_pair,
    input  logic [IMMW-1:0] word_imm,
    input  logic            ptr_en,
    input  logic [1:0]      ptr_sel,
    input  logic [1:0]      ptr_mode,
    input  logic [QW-1:0]   ptr_disp,
    input  logic            acc_st,
    input  logic [DW-1:0]   acc_wdata,
    output logic [PTRW-1:0] eff_addr,
    output logic [1:0]      region,
    output logic [7:0]      region_off,
    output logic            out_of_range,
    output logic [DW-1:0]   acc_rdata
);
    import rfp_pkg::*;

    localparam int X_PAIR = NREG / 2 - 3;

    logic [NREG-1:0][DW-1:0] regs_q;
    logic [PW-1:0]           ptr_pair;
    logic [PTRW-1:0]         ptr_val;
    logic                    agu_wb;
    logic [PTRW-1:0]         agu_val;
    logic [PTRW-1:0]         wd_old;
    logic [PTRW-1:0]         wd_val;
    logic                    st_hit;

    function automatic logic [PTRW-1:0] pair_word(input logic [PW-1:0] p);
        return {regs_q[{p, 1'b1}], regs_q[{p, 1'b0}]};
    endfunction

    // Operand read ports.
    assign rd_data_a = regs_q[rd_sel_a];
    assign rd_data_b = regs_q[rd_sel_b];

    // Pick the pointer pair; select codes 2 and 3 both mean Z.
    always_comb begin
        case (ptr_sel)
            2'd0:    ptr_pair = PW'(X_PAIR);
            2'd1:    ptr_pair = PW'(X_PAIR + 1);
            default: ptr_pair = PW'(X_PAIR + 2);
        endcase
    end
    assign ptr_val = pair_word(ptr_pair);

    rfp_agu #(.PTRW(PTRW), .QW(QW)) u_agu (
        .ptr_val  (ptr_val),
        .mode     (ptr_mode),
        .is_x     (ptr_sel == 2'd0),
        .disp     (ptr_disp),
        .eff_addr (eff_addr),
        .wb_en    (agu_wb),
        .wb_val   (agu_val)
    );

    rfp_region #(.AW(PTRW), .OW(8), .REG_SZ(NREG), .IO_SZ(IO_SZ), .RAM_SZ(RAM_SZ)) u_region (
        .addr   (eff_addr),
        .region (region),
        .offset (region_off),
        .oor    (out_of_range)
    );

    // Register-region load data; other regions are served outside the block.
    assign acc_rdata = (region_t'(region) == RG_REG) ? regs_q[region_off[SW-1:0]] : '0;
    assign st_hit    = ptr_en && acc_st && region_t'(region) == RG_REG;

    // Word add/subtract of a zero-extended immediate on a pair.
    assign wd_old = pair_word(word_pair);
    assign wd_val = word_sub ? wd_old - PTRW'(word_imm) : wd_old + PTRW'(word_imm);

    rfp_store #(.NREG(NREG), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .st_en   (st_hit),
        .st_sel  (region_off[SW-1:0]),
        .st_data (acc_wdata),
        .wb_en   (ptr_en && agu_wb),
        .wb_pair (ptr_pair),
        .wb_val  (agu_val),
        .wd_en   (word_en),
        .wd_pair (word_pair),
        .wd_val  (wd_val),
        .regs_q  (regs_q)
    );

    // R3: an undisturbed post-increment leaves the pointer one above the address used.
    a_r3_postinc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_en && ptr_mode == 2'd1 && !wr_en && !word_en && !st_hit)
        |=> pair_word($past(ptr_pair)) == $past(eff_addr) + PTRW'(1));

    // R5: an undisturbed plain access keeps the pointer unchanged.
    a_r5_plain_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_en && ptr_mode == 2'd0 && !wr_en && !word_en && !st_hit)
        |=> pair_word($past(ptr_pair)) == $past(ptr_val));

    // R9: out-of-range addresses read as zero.
    a_r9_oor_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        out_of_range |-> acc_rdata == '0);

    // R8: the register region is reported only for addresses below the file size.
    a_r8_reg_region_bound: assert property (@(posedge clk) disable iff (!rst_n)
        region == 2'd0 |-> eff_addr < PTRW'(NREG));
endmodule

// File: tb/regfile_ptr_test.sv
`timescale 1ns/1ps
module regfile_ptr_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  rd_sel_a = '0, rd_sel_b = '0;
    logic [7:0]  rd_data_a, rd_data_b;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic        word_en = 1'b0, word_sub = 1'b0;
    logic [3:0]  word_pair = '0;
    logic [5:0]  word_imm = '0;
    logic        ptr_en = 1'b0;
    logic [1:0]  ptr_sel = '0, ptr_mode = '0;
    logic [5:0]  ptr_disp = '0;
    logic        acc_st = 1'b0;
    logic [7:0]  acc_wdata = '0;
    logic [15:0] eff_addr;
    logic [1:0]  region;
    logic [7:0]  region_off;
    logic        out_of_range;
    logic [7:0]  acc_rdata;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    regfile_ptr uut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wreg(input int i, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 5'(i); wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rreg(input int i, output logic [7:0] v);
        rd_sel_a = 5'(i);
        #1 v = rd_data_a;
    endtask

    task automatic setptr(input int p, input logic [15:0] v);
        wreg(26 + 2 * p, v[7:0]);
        wreg(27 + 2 * p, v[15:8]);
    endtask

    task automatic getptr(input int p, output logic [15:0] v);
        logic [7:0] lo, hi;
        rreg(26 + 2 * p, lo);
        rreg(27 + 2 * p, hi);
        v = {hi, lo};
    endtask

    // One indirect access cycle; the effective address is captured before the edge.
    task automatic access(input int p, input int mode, input int q, output logic [15:0] ea);
        @(negedge clk);
        ptr_en = 1'b1; ptr_sel = 2'(p); ptr_mode = 2'(mode); ptr_disp = 6'(q);
        #1 ea = eff_addr;
        @(negedge clk);
        ptr_en = 1'b0; acc_st = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        bit all_zero = 1'b1;
        wreg(5, 8'hA5);
        wreg(30, 8'h3C);
        do_reset();
        for (int i = 0; i < 32; i++) begin
            rreg(i, v);
            if (v !== 8'h00) all_zero = 1'b0;
        end
        check("R1 all registers zero after reset", 32'(all_zero), 32'd1);
    endtask

    task automatic t_ports();
        wreg(3, 8'h3C);
        wreg(17, 8'hC3);
        rd_sel_a = 5'd3; rd_sel_b = 5'd17;
        #1;
        check("R2 port A", 32'(rd_data_a), 32'h3C);
        check("R2 port B", 32'(rd_data_b), 32'hC3);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 5'd3; wr_data = 8'h99;
        #1 check("R2 old value before edge", 32'(rd_data_a), 32'h3C);
        @(negedge clk);
        wr_en = 1'b0;
        check("R2 new value after edge", 32'(rd_data_a), 32'h99);
    endtask

    task automatic t_postinc();
        logic [15:0] ea, p;
        logic [7:0] lo, hi;
        setptr(0, 16'h00FF);
        access(0, 1, 0, ea);
        check("R3 post-inc address", 32'(ea), 32'h00FF);
        getptr(0, p);
        check("R3 post-inc carry into high byte", 32'(p), 32'h0100);
        rreg(26, lo); rreg(27, hi);
        check("R7 X low byte at r26", 32'(lo), 32'h00);
        check("R7 X high byte at r27", 32'(hi), 32'h01);
    endtask

    task automatic t_predec();
        logic [15:0] ea, p;
        setptr(1, 16'h0100);
        access(1, 2, 0, ea);
        check("R4 pre-dec address", 32'(ea), 32'h00FF);
        getptr(1, p);
        check("R4 pre-dec borrow", 32'(p), 32'h00FF);
    endtask

    task automatic t_plain();
        logic [15:0] ea, p;
        setptr(2, 16'h0042);
        access(3, 0, 0, ea);
        check("R7 select 3 is Z", 32'(ea), 32'h0042);
        access(2, 0, 0, ea);
        check("R5 plain address", 32'(ea), 32'h0042);
        getptr(2, p);
        check("R5 plain pointer unchanged", 32'(p), 32'h0042);
    endtask

    task automatic t_disp();
        logic [15:0] ea, p;
        setptr(1, 16'h0070);
        access(1, 3, 63, ea);
        check("R6 Y+63", 32'(ea), 32'h00AF);
        getptr(1, p);
        check("R6 Y unchanged", 32'(p), 32'h0070);
        setptr(2, 16'h0010);
        access(2, 3, 0, ea);
        check("R6 Z+0", 32'(ea), 32'h0010);
        setptr(0, 16'h0050);
        access(0, 3, 5, ea);
        check("R6 X ignores displacement", 32'(ea), 32'h0050);
        getptr(0, p);
        check("R6 X unchanged", 32'(p), 32'h0050);
    endtask

    task automatic region_at(input logic [15:0] a, input int rg, input int off, input int oor);
        setptr(2, a);
        ptr_sel = 2'd2; ptr_mode = 2'd0;
        #1;
        check($sformatf("R8/R9 region at %h", a), 32'(region), 32'(rg));
        check($sformatf("R8/R9 offset at %h", a), 32'(region_off), 32'(off));
        check($sformatf("R8/R9 out_of_range at %h", a), 32'(out_of_range), 32'(oor));
    endtask

    task automatic t_region();
        region_at(16'h001F, 0, 8'h1F, 0);
        region_at(16'h0020, 1, 8'h00, 0);
        region_at(16'h005F, 1, 8'h3F, 0);
        region_at(16'h0060, 2, 8'h00, 0);
        region_at(16'h00DF, 2, 8'h7F, 0);
        region_at(16'h00E0, 3, 8'h00, 1);
        check("R9 read data zero above SRAM", 32'(acc_rdata), 32'h00);
        region_at(16'h1234, 3, 8'h00, 1);
    endtask

    task automatic t_indirect();
        logic [15:0] ea, p;
        logic [7:0] v;
        wreg(4, 8'h5A);
        setptr(2, 16'h0004);
        ptr_sel = 2'd2; ptr_mode = 2'd0;
        #1 check("R10 register-region load", 32'(acc_rdata), 32'h5A);
        setptr(2, 16'h0009);
        acc_st = 1'b1; acc_wdata = 8'h77;
        access(2, 0, 0, ea);
        rreg(9, v);
        check("R10 register-region store", 32'(v), 32'h77);
        wreg(16, 8'h11);
        setptr(2, 16'h0030);
        acc_st = 1'b1; acc_wdata = 8'hEE;
        access(2, 0, 0, ea);
        rreg(16, v);
        check("R10 I/O store leaves r16", 32'(v), 32'h11);
        getptr(2, p);
        check("R10 I/O store leaves Z", 32'(p), 32'h0030);
    endtask

    task automatic word_op(input int pr, input bit sub, input int imm);
        @(negedge clk);
        word_en = 1'b1; word_pair = 4'(pr); word_sub = sub; word_imm = 6'(imm);
        @(negedge clk);
        word_en = 1'b0;
    endtask

    task automatic t_word();
        logic [7:0] lo, hi;
        wreg(24, 8'hFF); wreg(25, 8'h00);
        word_op(12, 1'b0, 1);
        rreg(24, lo); rreg(25, hi);
        check("R11 add carries across bytes", 32'({hi, lo}), 32'h0100);
        wreg(2, 8'h01); wreg(3, 8'h00);
        word_op(1, 1'b1, 3);
        rreg(2, lo); rreg(3, hi);
        check("R11 subtract wraps", 32'({hi, lo}), 32'hFFFE);
        wreg(24, 8'hF0); wreg(25, 8'hFF);
        word_op(12, 1'b0, 63);
        rreg(24, lo); rreg(25, hi);
        check("R11 add 63 wraps", 32'({hi, lo}), 32'h002F);
    endtask

    task automatic t_collide();
        logic [7:0] lo, hi;
        setptr(0, 16'h0010);
        @(negedge clk);
        ptr_en = 1'b1; ptr_sel = 2'd0; ptr_mode = 2'd1;
        wr_en = 1'b1; wr_sel = 5'd26; wr_data = 8'hAB;
        @(negedge clk);
        ptr_en = 1'b0; wr_en = 1'b0;
        rreg(26, lo); rreg(27, hi);
        check("R12 byte write wins on r26", 32'(lo), 32'hAB);
        check("R12 other byte takes pointer update", 32'(hi), 32'h00);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_ports();
        t_postinc();
        t_predec();
        t_plain();
        t_disp();
        t_region();
        t_indirect();
        t_word();
        t_collide();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule